// File: doc/BRIEF.md
# Self-Checking Lockstep Output Comparator

This block watches the output words of two redundant processor channels that run the same program and decides whether they still agree. Channel B runs a fixed number of clock cycles behind channel A. The block holds channel A's word and valid flag in a short delay line, so that both streams describe the same program step when they meet. It then takes the exclusive-OR of each bit pair. A result bit of 0 means the two bits agree and 1 means they differ. A compare happens only in cycles where both aligned valid flags are high.

The block also tests its own compare logic while it runs. On every INJ_PERIOD-th compare cycle it inverts one bit of the B operand on purpose. Each injection moves to the next bit position, so over time every XOR cell is exercised. On that cycle the block expects exactly a one-hot difference vector at the injected position. It treats a match as a passed self-test and does not report it as a data error. Any other vector is a self-test failure, which exposes a comparator stuck at "agree". A real difference outside an injection cycle sets the data-mismatch flag.

Either error raises a latched fail-safe request. The request clears only through an explicit clear. A heartbeat output toggles on each passed self-test, so an external watchdog can confirm that checking is still going on.

Top module: `lockstep_cmp`

## Requirements
- R1: After reset (rst_ni low), fail_safe_o, mismatch_err_o, selftest_err_o and heartbeat_o are all 0, and the injection schedule and bit pointer restart.
- R2: Channel A's data and valid are delayed by LAG cycles (default 1) before the compare. Streams where B carries A's word LAG cycles later raise no error. Feeding both channels the same changing word in the same cycle raises mismatch_err_o.
- R3: A compare cycle is a cycle in which the delayed A valid and b_valid_i are both high. In any other cycle the data values have no effect on the flags, and the cycle does not advance the injection schedule.
- R4: On a compare cycle that is not an injection cycle, any bit that differs sets mismatch_err_o at the next clock edge, while selftest_err_o stays 0.
- R5: The INJ_PERIOD-th compare cycle after reset (default 8), and every INJ_PERIOD-th compare cycle after it, is an injection cycle. On it one B bit is inverted. The bit index starts at 0 and steps up by one per injection, wrapping after WIDTH-1.
- R6: On an injection cycle, a difference vector that is anything other than one-hot at the injected bit sets selftest_err_o at the next edge and leaves mismatch_err_o unchanged. This covers a real difference in another bit, and a real difference in the injected bit that cancels the injection.
- R7: fail_safe_o is high whenever mismatch_err_o or selftest_err_o is high. Each flag stays set until it is cleared.
- R8: clear_i clears both error flags at the next edge only if that cycle detects no new error. If the same cycle detects an error, the flag that error sets is 1 after the edge.
- R9: heartbeat_o toggles exactly at the edge that ends a passing injection cycle, and in no other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | WIDTH | Channel A output word (leading channel) |
| a_valid_i | input | 1 | Channel A word valid |
| b_data_i | input | WIDTH | Channel B output word (lags by LAG cycles) |
| b_valid_i | input | 1 | Channel B word valid |
| clear_i | input | 1 | Request to clear the latched error flags |
| fail_safe_o | output | 1 | Latched fail-safe request |
| mismatch_err_o | output | 1 | Latched real data mismatch |
| selftest_err_o | output | 1 | Latched self-test failure |
| heartbeat_o | output | 1 | Toggles on each passed self-test |

## Verification
The assertions assume that B's valid flag follows A's valid flag exactly LAG cycles later. They also assume that any difference seen on an injection cycle is always reported as a self-test fault, and never as a data mismatch. The bench generates channel B from a model register of channel A's previous word, so the lag always matches the default LAG of 1. Corruptions and invalid cycles are placed at compare indices counted from reset, so each lands on a known injection or non-injection cycle. Misaligned and invalid data are driven only in scenarios that check exactly those cases.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef struct packed {
    logic mismatch;
    logic selftest;
    logic heartbeat;
  } lsc_flags_t;
endpackage

// File: rtl/lsc_align.sv
module lsc_align #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LAG   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic [LAG-1:0][WIDTH-1:0] d_q;
  logic [LAG-1:0]            v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      v_q <= '0;
    end else begin
      d_q[0] <= data_i;
      v_q[0] <= valid_i;
      for (int s = 1; s < LAG; s++) begin
        d_q[s] <= d_q[s-1];
        v_q[s] <= v_q[s-1];
      end
    end
  end

  assign data_o  = d_q[LAG-1];
  assign valid_o = v_q[LAG-1];
endmodule

// File: rtl/lsc_tpg.sv
module lsc_tpg #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned INJ_PERIOD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_en_i,
  output logic             inj_o,
  output logic [WIDTH-1:0] mask_o
);
  import lsc_pkg::*;
  localparam int unsigned CW = idx_w(INJ_PERIOD);
  localparam int unsigned PW = idx_w(WIDTH);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ptr_q;

  assign inj_o = cmp_en_i && (cnt_q == CW'(INJ_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (cmp_en_i) begin
      cnt_q <= inj_o ? '0 : cnt_q + CW'(1);
      if (inj_o) ptr_q <= (ptr_q == PW'(WIDTH - 1)) ? '0 : ptr_q + PW'(1);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign mask_o[i] = inj_o && (ptr_q == PW'(i));
  end

  assert_onehot_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_o));
  assert_ptr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(WIDTH - 1));
  assert_mask_on_inj_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> $countones(mask_o) == 1);
endmodule

// File: rtl/lsc_xor_bank.sv
module lsc_xor_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] flip_i,
  output logic [WIDTH-1:0] diff_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic b_mod;
    assign b_mod     = b_i[i] ^ flip_i[i];
    assign diff_o[i] = a_i[i] ^ b_mod;
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned LAG        = 1,
  parameter int unsigned INJ_PERIOD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_data_i,
  input  logic             a_valid_i,
  input  logic [WIDTH-1:0] b_data_i,
  input  logic             b_valid_i,
  input  logic             clear_i,
  output logic             fail_safe_o,
  output logic             mismatch_err_o,
  output logic             selftest_err_o,
  output logic             heartbeat_o
);
  import lsc_pkg::*;

  logic [WIDTH-1:0] a_al, mask, diff;
  logic             a_v_al, cmp_en, inj;
  logic             mism_hit, st_hit, st_pass;
  lsc_flags_t       flg_q;

  lsc_align #(.WIDTH(WIDTH), .LAG(LAG)) u_align (
    .clk_i, .rst_ni, .data_i(a_data_i), .valid_i(a_valid_i),
    .data_o(a_al), .valid_o(a_v_al)
  );

  assign cmp_en = a_v_al && b_valid_i;

  lsc_tpg #(.WIDTH(WIDTH), .INJ_PERIOD(INJ_PERIOD)) u_tpg (
    .clk_i, .rst_ni, .cmp_en_i(cmp_en), .inj_o(inj), .mask_o(mask)
  );

  lsc_xor_bank #(.WIDTH(WIDTH)) u_xor (
    .a_i(a_al), .b_i(b_data_i), .flip_i(mask), .diff_o(diff)
  );

  // injected bit is expected back exactly; anything else on that cycle is a self-test fault
  assign mism_hit = cmp_en && !inj && (diff != '0);
  assign st_hit   = cmp_en &&  inj && (diff != mask);
  assign st_pass  = cmp_en &&  inj && (diff == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
    end else begin
      if (clear_i && !mism_hit && !st_hit) begin
        flg_q.mismatch <= 1'b0;
        flg_q.selftest <= 1'b0;
      end else begin
        if (mism_hit) flg_q.mismatch <= 1'b1;
        if (st_hit)   flg_q.selftest <= 1'b1;
      end
      if (st_pass) flg_q.heartbeat <= ~flg_q.heartbeat;
    end
  end

  assign mismatch_err_o = flg_q.mismatch;
  assign selftest_err_o = flg_q.selftest;
  assign heartbeat_o    = flg_q.heartbeat;
  assign fail_safe_o    = flg_q.mismatch | flg_q.selftest;

  assert_mism_off_inj_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mismatch_err_o) |-> $past(cmp_en && !inj));
  assert_st_on_inj_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selftest_err_o) |-> $past(inj));
  assert_no_cmp_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en |=> !$rose(mismatch_err_o) && !$rose(selftest_err_o));
  assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_err_o && !clear_i) |=> mismatch_err_o);
  assert_failsafe_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_safe_o && !clear_i) |=> fail_safe_o);
  assert_hb_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (heartbeat_o != $past(heartbeat_o)) |-> $past(inj));
endmodule

// File: tb/sim_lockstep_cmp.sv
module sim_lockstep_cmp;
  localparam int W = 8;
  localparam int P = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         a_valid = 1'b0, b_valid = 1'b0, clear = 1'b0;
  logic         fail_safe, mism, st, hb;

  logic [W-1:0] prev_a;
  logic         prev_av;
  int           checks = 0, fails = 0;

  always #5 clk = ~clk;

  lockstep_cmp #(.WIDTH(W), .LAG(1), .INJ_PERIOD(P)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_data_i(a_data), .a_valid_i(a_valid),
    .b_data_i(b_data), .b_valid_i(b_valid), .clear_i(clear),
    .fail_safe_o(fail_safe), .mismatch_err_o(mism), .selftest_err_o(st),
    .heartbeat_o(hb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input int m, input int s, input int h);
    chk({req, " mismatch"}, int'(mism), m);
    chk({req, " selftest"}, int'(st), s);
    chk({req, " fail_safe"}, int'(fail_safe), (m | s));
    chk({req, " heartbeat"}, int'(hb), h);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; a_data = '0; b_data = '0; a_valid = 0; b_valid = 0; clear = 0;
    prev_a = '0; prev_av = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step_raw(input logic [W-1:0] a, input logic av,
                          input logic [W-1:0] b, input logic bv, input logic clr);
    @(negedge clk);
    a_data = a; a_valid = av; b_data = b; b_valid = bv; clear = clr;
    prev_a = a; prev_av = av;
    @(posedge clk);
    #2;
  endtask

  // B replays A one cycle later, optionally with bits flipped
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] flip, input logic clr);
    step_raw(a, 1'b1, prev_a ^ flip, prev_av, clr);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    flags("R1 reset", 0, 0, 0);
  endtask

  task automatic t_clean_stream();
    int ncmp = 0;
    int hb_exp = 0;
    do_reset();
    for (int k = 0; k < P * W + 4; k++) begin
      logic compared;
      compared = prev_av;
      step(W'(k * 37 + 5), '0, 1'b0);
      if (compared) begin
        ncmp++;
        if (ncmp % P == 0) hb_exp ^= 1;
      end
      flags("R2 R5 R9 clean lockstep", 0, 0, hb_exp);
    end
  endtask

  task automatic t_mismatch_clear();
    do_reset();
    step(8'h10, '0, 0);                            // no compare yet
    for (int k = 1; k <= 3; k++) step(W'(8'h10 + k), '0, 0);
    step(8'h40, 8'h04, 0);                         // compare 4, not injection
    flags("R4 mismatch off injection", 1, 0, 0);
    step(8'h41, '0, 0);
    step(8'h42, '0, 0);
    flags("R7 latched", 1, 0, 0);
    step(8'h43, '0, 1);                            // compare 7 clean with clear
    flags("R8 clear", 0, 0, 0);
    step(8'h44, '0, 0);                            // compare 8 injection passes
    flags("R9 heartbeat after clear", 0, 0, 1);
    step(8'h45, 8'h80, 1);                         // clear with new error
    flags("R8 clear blocked by new error", 1, 0, 1);
  endtask

  task automatic t_valid_gate();
    do_reset();
    step_raw(8'hAA, 0, 8'h55, 1, 0);
    step_raw(8'h11, 1, 8'hFF, 1, 0);               // aligned A invalid
    flags("R3 aligned A invalid ignored", 0, 0, 0);
    step_raw(8'h22, 1, 8'h00, 0, 0);               // B invalid
    flags("R3 B invalid ignored", 0, 0, 0);
    for (int k = 1; k <= P; k++) begin
      step(W'(8'h30 + k), '0, 0);
      if (k == P - 1) flags("R3 schedule not advanced", 0, 0, 0);
    end
    flags("R3 R5 first injection on compare P", 0, 0, 1);
  endtask

  task automatic t_misaligned();
    do_reset();
    step_raw(8'h01, 1, 8'h01, 1, 0);
    step_raw(8'h02, 1, 8'h02, 1, 0);
    flags("R2 same-cycle feed misaligned", 1, 0, 0);
  endtask

  task automatic t_selftest(input logic [W-1:0] flip, input string req);
    do_reset();
    step(8'h50, '0, 0);
    for (int k = 1; k < P; k++) step(W'(8'h50 + k), '0, 0);
    flags({req, " before injection"}, 0, 0, 0);
    step(8'h60, flip, 0);                          // compare P: injection on bit 0
    flags(req, 0, 1, 0);
  endtask

  initial begin
    t_reset();
    t_clean_stream();
    t_mismatch_clear();
    t_valid_gate();
    t_misaligned();
    t_selftest(8'h20, "R6 R9 extra bit on injection");
    t_selftest(8'h01, "R6 R9 injected bit cancelled");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule